// File: doc/BRIEF.md
# CPU Idle State Entry Controller

This chipset-side controller moves the processor into one of three idle depths (C2, C3 or C4) and back to full operation. Software starts an entry by reading one of three level addresses. The read returns zero data. The controller then asserts a cumulative set of active-low sideband lines, one after another, and trades a short series of handshake messages with the CPU-side agent. A fourth address returns the idle depth currently held.

The depth picks how many sideband lines are asserted. C2 uses only the stop-clock request. C3 adds CPU sleep, deep sleep and stop-CPU-clock. C4 adds the deeper-stop line and the regulator low-voltage line on top of that. The deeper states allow only isochronous bus masters, so a C3 or C4 read made while a non-isochronous master is active is served as C2. An unmasked interrupt, SMI, NMI, a bus-master snoop request or the floating-point error line ends the idle period. The lines are then released in reverse order, with a programmable gap between steps. The stop-clock request is held until the agent acknowledges the return to C0.

Top module: `cidle_ctrl`

## Requirements
- R1: After reset, all six sideband lines are high (deasserted), no message is sent and a status read (address 0) returns 0.
- R2: A read of address 1 drives the stop-clock line (side bit 0) low and then sends REQ_C2 (code 1). On GO_C2 (input code 1) it answers ACK_C2 (code 2) and holds C2 with only bit 0 low. The status then reads 2.
- R3: A read of address 2 does the C2 exchange and then sends WAIT_C3 (code 3). On GO_C3 (input code 2) it answers ACK_C3 (code 4). Bits 1 (CPU sleep), 2 (deep sleep) and 3 (stop-CPU-clock) then go low in that order, gap+1 cycles apart, the first one gap+1 cycles after ACK_C3. The status then reads 3.
- R4: A read of address 3 behaves like address 2 and then also drives bit 4 (deeper stop) and bit 5 (regulator low) low, with the same spacing. The status then reads 4.
- R5: The asserted lines always form a contiguous run starting at bit 0, and at most one line changes per cycle.
- R6: A read of address 2 or 3 while the non-isochronous bus-master input is high enters C2 instead.
- R7: On a break event in a held state, the lines above bit 0 are released from the highest down, gap+1 cycles apart. GO_C0 (code 5) follows gap+1 cycles after the last of them, or in the break cycle itself for C2. Bit 0 stays low until ACK_C0 (input code 3) arrives, and the status reads 0 from the start of the exit.
- R8: A break event that occurs during entry is remembered, and the exit begins one cycle after the target state is reached.
- R9: Every read produces a read-valid pulse one cycle later. Level reads (addresses 1 to 3) return zero data, and address 0 returns the status.
- R10: A level read made while not in C0 changes neither the lines nor the status, and sends no message.
- R11: Each of the five break sources on its own (interrupt, SMI, NMI, snoop, floating-point error) starts the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | 0 status, 1 C2 level, 2 C3 level, 3 C4 level |
| rd_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_data_o | output | DATA_W | Read data |
| gap_i | input | GAP_W | Cycles between sideband steps, minus one |
| bm_busy_i | input | 1 | A non-isochronous bus master is active |
| irq_i | input | 1 | Unmasked interrupt break event |
| smi_i | input | 1 | SMI break event |
| nmi_i | input | 1 | NMI break event |
| snoop_i | input | 1 | Bus-master snoop request break event |
| ferr_i | input | 1 | Floating-point error break event |
| msg_in_valid_i | input | 1 | Message from the CPU-side agent is valid |
| msg_in_code_i | input | 3 | Incoming code: 1 GO_C2, 2 GO_C3, 3 ACK_C0 |
| msg_out_valid_o | output | 1 | Outgoing message is valid for one cycle |
| msg_out_code_o | output | 3 | Outgoing code: 1 REQ_C2, 2 ACK_C2, 3 WAIT_C3, 4 ACK_C3, 5 GO_C0 |
| side_n_o | output | 6 | Active-low lines: 0 stop-clock, 1 CPU sleep, 2 deep sleep, 3 stop-CPU-clock, 4 deeper stop, 5 regulator low |
| cstate_o | output | 3 | Held idle depth: 0, 2, 3 or 4 |

## Verification
On every cycle, the assertions check the shape of the sideband vector: a contiguous run that changes by one line per step. They check that each reported depth matches its line count, that stop-clock is released only right after ACK_C0, and that level reads return zero data. The order and timing of each handshake, the gap+1 spacing in both directions, the fallback to C2, the remembered break during entry and the ignored reads in a held state are shown only by the bench's directed scenarios, which measure cycle distances at the ports.

// File: rtl/cidle_pkg.sv
`timescale 1ns/1ps
package cidle_pkg;
    localparam int SB_N  = 6;
    localparam int SB_CW = $clog2(SB_N + 1);

    localparam logic [2:0] DEPTH_C0 = 3'd0;
    localparam logic [2:0] DEPTH_C2 = 3'd2;
    localparam logic [2:0] DEPTH_C3 = 3'd3;
    localparam logic [2:0] DEPTH_C4 = 3'd4;

    localparam int C3_LINES = 4;

    // outgoing message codes
    localparam logic [2:0] MO_REQ_C2  = 3'd1;
    localparam logic [2:0] MO_ACK_C2  = 3'd2;
    localparam logic [2:0] MO_WAIT_C3 = 3'd3;
    localparam logic [2:0] MO_ACK_C3  = 3'd4;
    localparam logic [2:0] MO_GO_C0   = 3'd5;

    // incoming message codes
    localparam logic [2:0] MI_GO_C2  = 3'd1;
    localparam logic [2:0] MI_GO_C3  = 3'd2;
    localparam logic [2:0] MI_ACK_C0 = 3'd3;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_REQ2,
        PH_WGO2,
        PH_WAIT3,
        PH_WGO3,
        PH_RAMP,
        PH_REST,
        PH_FALL,
        PH_WACK0
    } phase_e;

    // number of sideband lines held low for a depth
    function automatic logic [SB_CW-1:0] lines_for(input logic [2:0] depth);
        case (depth)
            DEPTH_C3: lines_for = SB_CW'(C3_LINES);
            DEPTH_C4: lines_for = SB_CW'(SB_N);
            default:  lines_for = SB_CW'(1);
        endcase
    endfunction
endpackage

// File: rtl/cidle_gap_timer.sv
`timescale 1ns/1ps
module cidle_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] gap,
    output logic             done
);
    logic [GAP_W-1:0] left_d, left_q;

    always_comb begin
        if (start) begin
            left_d = gap;
        end else if (left_q != '0) begin
            left_d = left_q - GAP_W'(1);
        end else begin
            left_d = left_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign done = (left_q == '0);
endmodule

// File: rtl/cidle_break_merge.sv
`timescale 1ns/1ps
module cidle_break_merge #(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic            busy,
    input  logic            clear,
    output logic            wake
);
    logic any_src;
    logic pend_d, pend_q;

    assign any_src = |src;

    always_comb begin
        if (clear) begin
            pend_d = 1'b0;
        end else begin
            pend_d = pend_q | (any_src & busy);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign wake = any_src | pend_q;
endmodule

// File: rtl/cidle_level_decode.sv
`timescale 1ns/1ps
module cidle_level_decode (
    input  logic       rd_valid,
    input  logic [1:0] rd_addr,
    input  logic       bm_busy,
    input  logic       idle,
    output logic       enter,
    output logic [2:0] depth
);
    import cidle_pkg::*;

    always_comb begin
        enter = rd_valid && idle && (rd_addr != 2'd0);
        case (rd_addr)
            2'd2:    depth = bm_busy ? DEPTH_C2 : DEPTH_C3;
            2'd3:    depth = bm_busy ? DEPTH_C2 : DEPTH_C4;
            default: depth = DEPTH_C2;
        endcase
    end
endmodule

// File: rtl/cidle_ctrl.sv
`timescale 1ns/1ps
module cidle_ctrl #(
    parameter int DATA_W = 8,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid_i,
    input  logic [1:0]        rd_addr_i,
    output logic              rd_rvalid_o,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [GAP_W-1:0]  gap_i,
    input  logic              bm_busy_i,
    input  logic              irq_i,
    input  logic              smi_i,
    input  logic              nmi_i,
    input  logic              snoop_i,
    input  logic              ferr_i,
    input  logic              msg_in_valid_i,
    input  logic [2:0]        msg_in_code_i,
    output logic              msg_out_valid_o,
    output logic [2:0]        msg_out_code_o,
    output logic [5:0]        side_n_o,
    output logic [2:0]        cstate_o
);
    import cidle_pkg::*;

    localparam int NSRC = 5;

    typedef struct packed {
        phase_e            ph;
        logic [SB_N-1:0]   sb;
        logic [SB_CW-1:0]  cnt;
        logic [SB_CW-1:0]  need;
        logic [2:0]        tgt;
        logic [2:0]        cst;
        logic              mv;
        logic [2:0]        mc;
        logic              rv;
        logic [DATA_W-1:0] rd;
    } ctl_t;

    ctl_t st_d, st_q;

    logic            enter;
    logic [2:0]      depth;
    logic            wake;
    logic            brk_clear;
    logic            tmr_start;
    logic            tmr_done;
    logic [NSRC-1:0] brk_src;

    assign brk_src = {ferr_i, snoop_i, nmi_i, smi_i, irq_i};

    cidle_level_decode u_dec (
        .rd_valid (rd_valid_i),
        .rd_addr  (rd_addr_i),
        .bm_busy  (bm_busy_i),
        .idle     (st_q.ph == PH_IDLE),
        .enter    (enter),
        .depth    (depth)
    );

    cidle_break_merge #(.NSRC(NSRC)) u_brk (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (brk_src),
        .busy  (st_q.ph != PH_IDLE),
        .clear (brk_clear),
        .wake  (wake)
    );

    cidle_gap_timer #(.GAP_W(GAP_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .gap   (gap_i),
        .done  (tmr_done)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mv   = 1'b0;
        st_d.mc   = 3'd0;
        st_d.rv   = rd_valid_i;
        st_d.rd   = (rd_valid_i && rd_addr_i == 2'd0) ? DATA_W'(st_q.cst) : '0;
        tmr_start = 1'b0;
        brk_clear = 1'b0;

        case (st_q.ph)
            PH_IDLE: begin
                brk_clear = 1'b1;
                if (enter) begin
                    st_d.sb[0] = 1'b1;
                    st_d.cnt   = SB_CW'(1);
                    st_d.need  = lines_for(depth);
                    st_d.tgt   = depth;
                    st_d.ph    = PH_REQ2;
                end
            end
            PH_REQ2: begin
                st_d.mv = 1'b1;
                st_d.mc = MO_REQ_C2;
                st_d.ph = PH_WGO2;
            end
            PH_WGO2: begin
                if (msg_in_valid_i && msg_in_code_i == MI_GO_C2) begin
                    st_d.mv = 1'b1;
                    st_d.mc = MO_ACK_C2;
                    if (st_q.tgt == DEPTH_C2) begin
                        st_d.ph  = PH_REST;
                        st_d.cst = st_q.tgt;
                    end else begin
                        st_d.ph = PH_WAIT3;
                    end
                end
            end
            PH_WAIT3: begin
                st_d.mv = 1'b1;
                st_d.mc = MO_WAIT_C3;
                st_d.ph = PH_WGO3;
            end
            PH_WGO3: begin
                if (msg_in_valid_i && msg_in_code_i == MI_GO_C3) begin
                    st_d.mv   = 1'b1;
                    st_d.mc   = MO_ACK_C3;
                    st_d.ph   = PH_RAMP;
                    tmr_start = 1'b1;
                end
            end
            PH_RAMP: begin
                if (tmr_done) begin
                    st_d.sb[st_q.cnt] = 1'b1;
                    st_d.cnt          = st_q.cnt + SB_CW'(1);
                    if ((st_q.cnt + SB_CW'(1)) == st_q.need) begin
                        st_d.ph  = PH_REST;
                        st_d.cst = st_q.tgt;
                    end else begin
                        tmr_start = 1'b1;
                    end
                end
            end
            PH_REST: begin
                if (wake) begin
                    brk_clear = 1'b1;
                    st_d.cst  = DEPTH_C0;
                    if (st_q.cnt == SB_CW'(1)) begin
                        st_d.mv = 1'b1;
                        st_d.mc = MO_GO_C0;
                        st_d.ph = PH_WACK0;
                    end else begin
                        st_d.ph   = PH_FALL;
                        tmr_start = 1'b1;
                    end
                end
            end
            PH_FALL: begin
                if (tmr_done) begin
                    if (st_q.cnt > SB_CW'(1)) begin
                        st_d.sb[st_q.cnt - SB_CW'(1)] = 1'b0;
                        st_d.cnt  = st_q.cnt - SB_CW'(1);
                        tmr_start = 1'b1;
                    end else begin
                        st_d.mv = 1'b1;
                        st_d.mc = MO_GO_C0;
                        st_d.ph = PH_WACK0;
                    end
                end
            end
            PH_WACK0: begin
                if (msg_in_valid_i && msg_in_code_i == MI_ACK_C0) begin
                    st_d.sb  = '0;
                    st_d.cnt = '0;
                    st_d.cst = DEPTH_C0;
                    st_d.ph  = PH_IDLE;
                end
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, tgt: DEPTH_C0, cst: DEPTH_C0, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_rvalid_o     = st_q.rv;
    assign rd_data_o       = st_q.rd;
    assign msg_out_valid_o = st_q.mv;
    assign msg_out_code_o  = st_q.mc;
    assign side_n_o        = ~st_q.sb;
    assign cstate_o        = st_q.cst;
endmodule

// File: rtl/cidle_chk.sv
`timescale 1ns/1ps
module cidle_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid_i,
    input logic [1:0]        rd_addr_i,
    input logic              rd_rvalid_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              msg_in_valid_i,
    input logic [2:0]        msg_in_code_i,
    input logic [5:0]        side_n_o,
    input logic [2:0]        cstate_o
);
    logic [5:0] act;
    assign act = ~side_n_o;

    assert_thermo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((act + 6'd1) & act) == 6'd0);

    assert_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(act ^ $past(act)) <= 1);

    assert_c2_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cstate_o == 3'd2 |-> $countones(act) == 1);

    assert_c3_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cstate_o == 3'd3 |-> $countones(act) == 4);

    assert_c4_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cstate_o == 3'd4 |-> $countones(act) == 6);

    assert_release_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(side_n_o[0]) |-> $past(msg_in_valid_i && msg_in_code_i == 3'd3));

    assert_level_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && rd_addr_i != 2'd0) |=> (rd_rvalid_o && rd_data_o == '0));

    assert_status_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cstate_o == 3'd0 || cstate_o == 3'd2 || cstate_o == 3'd3 || cstate_o == 3'd4);
endmodule

bind cidle_ctrl cidle_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_valid_i     (rd_valid_i),
    .rd_addr_i      (rd_addr_i),
    .rd_rvalid_o    (rd_rvalid_o),
    .rd_data_o      (rd_data_o),
    .msg_in_valid_i (msg_in_valid_i),
    .msg_in_code_i  (msg_in_code_i),
    .side_n_o       (side_n_o),
    .cstate_o       (cstate_o)
);

// File: tb/tb_cidle_ctrl.sv
`timescale 1ns/1ps
module tb_cidle_ctrl;
    localparam int DATA_W = 8;
    localparam int GAP_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_valid = 1'b0;
    logic [1:0]        rd_addr = 2'd0;
    logic              rd_rvalid;
    logic [DATA_W-1:0] rd_data;
    logic [GAP_W-1:0]  gap = '0;
    logic              bm_busy = 1'b0;
    logic [4:0]        brk = '0;
    logic              mi_valid = 1'b0;
    logic [2:0]        mi_code = 3'd0;
    logic              mo_valid;
    logic [2:0]        mo_code;
    logic [5:0]        side_n;
    logic [2:0]        cstate;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cidle_ctrl #(.DATA_W(DATA_W), .GAP_W(GAP_W)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .rd_valid_i      (rd_valid),
        .rd_addr_i       (rd_addr),
        .rd_rvalid_o     (rd_rvalid),
        .rd_data_o       (rd_data),
        .gap_i           (gap),
        .bm_busy_i       (bm_busy),
        .irq_i           (brk[0]),
        .smi_i           (brk[1]),
        .nmi_i           (brk[2]),
        .snoop_i         (brk[3]),
        .ferr_i          (brk[4]),
        .msg_in_valid_i  (mi_valid),
        .msg_in_code_i   (mi_code),
        .msg_out_valid_o (mo_valid),
        .msg_out_code_o  (mo_code),
        .side_n_o        (side_n),
        .cstate_o        (cstate)
    );

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int nact();
        return $countones(~side_n);
    endfunction

    task automatic wait_msg(input logic [2:0] code, output int at);
        at = -1;
        for (int i = 0; i < 200; i++) begin
            if (mo_valid && mo_code == code) begin
                at = cyc;
                break;
            end
            tick();
        end
    endtask

    task automatic wait_lines(input int k, output int at);
        at = -1;
        for (int i = 0; i < 200; i++) begin
            if (nact() == k) begin
                at = cyc;
                break;
            end
            tick();
        end
    endtask

    task automatic send(input logic [2:0] code);
        mi_valid = 1'b1;
        mi_code  = code;
        tick();
        mi_valid = 1'b0;
        mi_code  = 3'd0;
    endtask

    task automatic read_reg(input logic [1:0] a, output int data);
        rd_valid = 1'b1;
        rd_addr  = a;
        tick();
        rd_valid = 1'b0;
        rd_addr  = 2'd0;
        chk(int'(rd_rvalid), 1, "R9 read valid");
        data = int'(rd_data);
    endtask

    // Runs a full entry; returns cycle at which the target line count appears.
    task automatic do_entry(input logic [1:0] a, input int g, input int need,
                            input int early_brk, output int t_full);
        int d, t, prev;
        gap = GAP_W'(g);
        read_reg(a, d);
        chk(d, 0, "R9 level read data");
        chk(int'(side_n[0]), 0, "R2 stop-clock low after level read");
        wait_msg(3'd1, t);
        chk(int'(t >= 0), 1, "R2 REQ_C2 sent");
        if (early_brk >= 0) begin
            brk[early_brk] = 1'b1;
            tick();
            brk = '0;
        end
        send(3'd1);
        wait_msg(3'd2, t);
        chk(int'(t >= 0), 1, "R2 ACK_C2 sent");
        prev = t;
        t_full = t;
        if (need > 1) begin
            chk(nact(), 1, "R3 only stop-clock during handshake");
            wait_msg(3'd3, t);
            chk(int'(t >= 0), 1, "R3 WAIT_C3 sent");
            send(3'd2);
            wait_msg(3'd4, t);
            chk(int'(t >= 0), 1, "R3 ACK_C3 sent");
            prev = t;
            for (int k = 2; k <= need; k++) begin
                wait_lines(k, t);
                chk(t - prev, g + 1, need == 6 ? "R4 entry step spacing" : "R3 entry step spacing");
                prev = t;
            end
            t_full = t;
        end
        chk(nact(), need, "R5 line count at target");
    endtask

    // Exit: src >= 0 pulses that break source, else relies on a pending break.
    task automatic do_exit(input int src, input int g, input int need, input int t_full);
        int base, t, prev, d;
        if (src >= 0) begin
            brk[src] = 1'b1;
            tick();
            brk = '0;
            base = cyc;
        end else begin
            base = t_full + 1;
        end
        prev = base;
        for (int k = need - 1; k >= 1; k--) begin
            wait_lines(k, t);
            chk(t - prev, g + 1, "R7 exit step spacing");
            prev = t;
        end
        wait_msg(3'd5, t);
        chk(t - prev, (need == 1) ? 0 : g + 1, src >= 0 ? "R7 GO_C0 timing" : "R8 GO_C0 timing");
        chk(int'(cstate), 0, "R7 status cleared at exit");
        tick(); tick(); tick();
        chk(int'(side_n[0]), 0, "R7 stop-clock held until ACK_C0");
        send(3'd3);
        chk(int'(side_n), 63, "R7 all lines released after ACK_C0");
        read_reg(2'd0, d);
        chk(d, 0, "R7 status reads 0 after exit");
    endtask

    task automatic t_reset();
        int d;
        chk(int'(side_n), 63, "R1 lines high after reset");
        chk(int'(mo_valid), 0, "R1 no message after reset");
        read_reg(2'd0, d);
        chk(d, 0, "R1 status 0 after reset");
    endtask

    task automatic t_c2_and_ignored_read();
        int tf, d, seen;
        do_entry(2'd1, 2, 1, -1, tf);
        read_reg(2'd0, d);
        chk(d, 2, "R2 status 2");
        // R10: a deeper level read while held in C2 changes nothing
        read_reg(2'd3, d);
        chk(d, 0, "R9 level read data while held");
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (mo_valid) seen++;
            tick();
        end
        chk(seen, 0, "R10 no message after read in C2");
        chk(nact(), 1, "R10 lines unchanged after read in C2");
        read_reg(2'd0, d);
        chk(d, 2, "R10 status unchanged");
        do_exit(0, 2, 1, tf);
    endtask

    task automatic t_c3();
        int tf, d;
        do_entry(2'd2, 3, 4, -1, tf);
        read_reg(2'd0, d);
        chk(d, 3, "R3 status 3");
        do_exit(3, 3, 4, tf);
    endtask

    task automatic t_c4(input int g);
        int tf, d;
        do_entry(2'd3, g, 6, -1, tf);
        read_reg(2'd0, d);
        chk(d, 4, "R4 status 4");
        do_exit(2, g, 6, tf);
    endtask

    task automatic t_fallback(input logic [1:0] a, input int src);
        int tf, d;
        bm_busy = 1'b1;
        do_entry(a, 1, 1, -1, tf);
        bm_busy = 1'b0;
        read_reg(2'd0, d);
        chk(d, 2, "R6 fallback status 2");
        chk(nact(), 1, "R6 only stop-clock in fallback");
        do_exit(src, 1, 1, tf);
    endtask

    task automatic t_pending();
        int tf;
        do_entry(2'd2, 1, 4, 0, tf);
        do_exit(-1, 1, 4, tf);
    endtask

    task automatic t_each_source();
        int tf;
        for (int s = 0; s < 5; s++) begin
            do_entry(2'd1, 0, 1, -1, tf);
            do_exit(s, 0, 1, tf);   // R11 every break source exits
        end
    endtask

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_c2_and_ignored_read();
        t_c3();
        t_c4(0);
        t_c4(5);
        t_fallback(2'd2, 1);
        t_fallback(2'd3, 4);
        t_pending();
        t_each_source();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule